// File: doc/BRIEF.md
# Planar Graphics Memory Datapath

This block sits between a CPU byte port and a display memory built from four 8-bit planes that share one address, so every memory word is 32 bits wide with plane p in bits 8p+7:8p. Each CPU read fetches the full word and keeps a copy in a hidden 32-bit latch. It returns one byte, selected or formed by the read mode. Each CPU write builds a full 32-bit word from four inputs: the CPU byte, a colour register and the latch. A rotator, a per-plane logic unit, a bit mask and one of four write modes combine them. A plane-enable field then decides which planes the memory actually updates.

Software programs the behaviour through an indexed register port: one cycle with an index and a data byte. The display refresh path, the CPU bus protocol and any chained or odd/even addressing belong to neighbouring blocks. The memory is assumed to return read data one cycle after a read request and to apply writes per plane enable.

Top module: `plane_rw_path`

## Requirements
- R1: After reset no memory request is active, `cpu_rvalid` is low, and the latch is zero. The register state is: write mode 0, read mode 0, rotate 0, logic op pass, set/reset enable 0, set/reset value 0, compare value 0, care mask 0, read plane 0, bit mask all ones, plane enable all ones.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the register at `cfg_idx`, effective from the next cycle. The indices are: 0 set/reset value, 1 set/reset enable, 2 compare value, 3 rotate/op, 4 read plane select, 5 mode, 6 care mask, 7 bit mask, 8 plane enable.
- R3: A CPU read drives `mem_rd` with `mem_addr` = `cpu_addr` in the same cycle. In the next cycle `cpu_rvalid` is high with the result, and the whole 32-bit word is loaded into the latch at the end of that cycle.
- R4: In the rotate/op register, bits 2:0 rotate the CPU byte right, and bits 4:3 pick the logic op applied with the latch plane: 0 pass, 1 AND, 2 OR, 3 XOR.
- R5: In write mode 0 (mode bits 1:0 = 0), a plane whose set/reset enable bit is 1 uses its set/reset value bit repeated over 8 bits instead of the rotated CPU byte.
- R6: In write modes 0, 2 and 3, each bit position with mask bit 1 takes the logic-unit result and each with mask bit 0 keeps the latch bit.
- R7: Write mode 1 writes the latch word unchanged and ignores the CPU byte and the bit mask.
- R8: In write mode 2, CPU data bit p, repeated over 8 bits, is the source for plane p.
- R9: In write mode 3, the source for plane p is set/reset value bit p repeated, and the mask in use is the rotated CPU byte ANDed with the bit mask.
- R10: A CPU write drives `mem_wr` in the same cycle, with `mem_wen` equal to the plane-enable register.
- R11: In read mode 0 (mode bit 3 = 0), `cpu_rdata` is the plane chosen by the read plane select.
- R12: In read mode 1, bit i of `cpu_rdata` is 1 exactly when, for every plane p with care-mask bit 1, bit i of plane p equals compare bit p.
- R13: A write issued in the cycle `cpu_rvalid` is high uses the word just read as its latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | PIX_W | Register write data |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | PIX_W | CPU write byte |
| cpu_rdata | output | PIX_W | CPU read result |
| cpu_rvalid | output | 1 | Read result valid |
| mem_addr | output | ADDR_W | Plane memory address |
| mem_rd | output | 1 | Plane memory read |
| mem_wr | output | 1 | Plane memory write |
| mem_wen | output | PLANES | Per-plane write enable |
| mem_wdata | output | PLANES*PIX_W | Word to write |
| mem_rdata | input | PLANES*PIX_W | Word read, one cycle after `mem_rd` |

## Verification
The bench steps through all four logic ops at three rotate counts. A rotator turning the wrong way, or an AND and OR swapped, shows up as a wrong plane byte. A mask applied before the logic op instead of after it leaves masked-off bits changed. Mode 3 writes use a partly masked rotated byte, so a design that ignores one of the two masks writes the wrong pixels. In a write issued in the very cycle the read data comes back, a design without forwarding would combine with the stale latch. Compare reads with a partial care mask expose a design that treats the mask as exclusion rather than inclusion.

// File: rtl/plane_pkg.sv
package plane_pkg;
   localparam int CFG_IDX_W = 4;

   localparam logic [CFG_IDX_W-1:0] IDX_SR_VAL  = 4'd0;
   localparam logic [CFG_IDX_W-1:0] IDX_SR_EN   = 4'd1;
   localparam logic [CFG_IDX_W-1:0] IDX_CMP     = 4'd2;
   localparam logic [CFG_IDX_W-1:0] IDX_ROT_OP  = 4'd3;
   localparam logic [CFG_IDX_W-1:0] IDX_RD_SEL  = 4'd4;
   localparam logic [CFG_IDX_W-1:0] IDX_MODE    = 4'd5;
   localparam logic [CFG_IDX_W-1:0] IDX_CARE    = 4'd6;
   localparam logic [CFG_IDX_W-1:0] IDX_BITMASK = 4'd7;
   localparam logic [CFG_IDX_W-1:0] IDX_PLANE_EN = 4'd8;

   typedef enum logic [1:0] {
      WM_DIRECT = 2'd0,
      WM_LATCH  = 2'd1,
      WM_COLOR  = 2'd2,
      WM_FILL   = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      LOP_PASS = 2'd0,
      LOP_AND  = 2'd1,
      LOP_OR   = 2'd2,
      LOP_XOR  = 2'd3
   } lop_e;
endpackage

// File: rtl/plane_cfg_regs.sv
module plane_cfg_regs
   import plane_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int PIX_W  = 8,
   localparam int RW = $clog2(PIX_W),
   localparam int SW = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [PIX_W-1:0]     cfg_wdata,
   output logic [PLANES-1:0]    sr_val,
   output logic [PLANES-1:0]    sr_en,
   output logic [PLANES-1:0]    cmp_val,
   output logic [PLANES-1:0]    care,
   output logic [RW-1:0]        rot_cnt,
   output lop_e                 lop,
   output logic [SW-1:0]        rd_sel,
   output wmode_e               wmode,
   output logic                 rmode,
   output logic [PIX_W-1:0]     bit_mask,
   output logic [PLANES-1:0]    plane_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_val   <= '0;
         sr_en    <= '0;
         cmp_val  <= '0;
         care     <= '0;
         rot_cnt  <= '0;
         lop      <= LOP_PASS;
         rd_sel   <= '0;
         wmode    <= WM_DIRECT;
         rmode    <= 1'b0;
         bit_mask <= '1;
         plane_en <= '1;
      end else if (cfg_we) begin
         case (cfg_idx)
            IDX_SR_VAL:   sr_val   <= cfg_wdata[PLANES-1:0];
            IDX_SR_EN:    sr_en    <= cfg_wdata[PLANES-1:0];
            IDX_CMP:      cmp_val  <= cfg_wdata[PLANES-1:0];
            IDX_CARE:     care     <= cfg_wdata[PLANES-1:0];
            IDX_ROT_OP: begin
               rot_cnt <= cfg_wdata[RW-1:0];
               lop     <= lop_e'(cfg_wdata[RW+1:RW]);
            end
            IDX_RD_SEL:   rd_sel   <= cfg_wdata[SW-1:0];
            IDX_MODE: begin
               wmode <= wmode_e'(cfg_wdata[1:0]);
               rmode <= cfg_wdata[3];
            end
            IDX_BITMASK:  bit_mask <= cfg_wdata;
            IDX_PLANE_EN: plane_en <= cfg_wdata[PLANES-1:0];
            default: ;
         endcase
      end
   end

   // R2
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == IDX_MODE) |=> (wmode == wmode_e'($past(cfg_wdata[1:0]))));
endmodule

// File: rtl/plane_write_unit.sv
module plane_write_unit
   import plane_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int PIX_W  = 8,
   localparam int RW = $clog2(PIX_W),
   localparam int WW = PLANES * PIX_W
) (
   input  logic [PIX_W-1:0]  cpu_wdata,
   input  logic [WW-1:0]     latch,
   input  wmode_e            wmode,
   input  lop_e              lop,
   input  logic [RW-1:0]     rot_cnt,
   input  logic [PLANES-1:0] sr_val,
   input  logic [PLANES-1:0] sr_en,
   input  logic [PIX_W-1:0]  bit_mask,
   output logic [WW-1:0]     wdata
);
   logic [2*PIX_W-1:0] dbl;
   logic [PIX_W-1:0]   rot;
   logic [PIX_W-1:0]   eff_mask;

   assign dbl      = {cpu_wdata, cpu_wdata} >> rot_cnt;
   assign rot      = dbl[PIX_W-1:0];
   assign eff_mask = (wmode == WM_FILL) ? (rot & bit_mask) : bit_mask;

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic [PIX_W-1:0] lp, src, alu;
      assign lp = latch[p*PIX_W +: PIX_W];

      always_comb begin
         case (wmode)
            WM_COLOR: src = {PIX_W{cpu_wdata[p]}};
            WM_FILL:  src = {PIX_W{sr_val[p]}};
            default:  src = sr_en[p] ? {PIX_W{sr_val[p]}} : rot;
         endcase
         case (lop)
            LOP_AND: alu = src & lp;
            LOP_OR:  alu = src | lp;
            LOP_XOR: alu = src ^ lp;
            default: alu = src;
         endcase
      end

      assign wdata[p*PIX_W +: PIX_W] = (wmode == WM_LATCH) ? lp
                                     : ((alu & eff_mask) | (lp & ~eff_mask));
   end
endmodule

// File: rtl/plane_read_unit.sv
module plane_read_unit #(
   parameter int PLANES = 4,
   parameter int PIX_W  = 8,
   localparam int SW = (PLANES > 1) ? $clog2(PLANES) : 1,
   localparam int WW = PLANES * PIX_W
) (
   input  logic [WW-1:0]     word,
   input  logic              rmode,
   input  logic [SW-1:0]     rd_sel,
   input  logic [PLANES-1:0] cmp_val,
   input  logic [PLANES-1:0] care,
   output logic [PIX_W-1:0]  rdata
);
   logic [WW-1:0]    shifted;
   logic [PIX_W-1:0] match;

   assign shifted = word >> (int'(rd_sel) * PIX_W);

   for (genvar i = 0; i < PIX_W; i++) begin : g_pix
      logic [PLANES-1:0] colour;
      for (genvar p = 0; p < PLANES; p++) begin : g_col
         assign colour[p] = word[p*PIX_W + i];
      end
      assign match[i] = (((colour ^ cmp_val) & care) == '0);
   end

   assign rdata = rmode ? match : shifted[PIX_W-1:0];
endmodule

// File: rtl/plane_rw_path.sv
module plane_rw_path
   import plane_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int PIX_W  = 8,
   parameter int ADDR_W = 16,
   localparam int RW = $clog2(PIX_W),
   localparam int SW = (PLANES > 1) ? $clog2(PLANES) : 1,
   localparam int WW = PLANES * PIX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [PIX_W-1:0]     cfg_wdata,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [PIX_W-1:0]     cpu_wdata,
   output logic [PIX_W-1:0]     cpu_rdata,
   output logic                 cpu_rvalid,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [PLANES-1:0]    mem_wen,
   output logic [WW-1:0]        mem_wdata,
   input  logic [WW-1:0]        mem_rdata
);
   if (PLANES < 1 || PLANES > PIX_W) begin : g_bad_planes
      $error("PLANES must lie between 1 and PIX_W");
   end
   if (PIX_W < 4 || (1 << RW) != PIX_W) begin : g_bad_pix
      $error("PIX_W must be a power of two of at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   logic [PLANES-1:0] sr_val, sr_en, cmp_val, care, plane_en;
   logic [RW-1:0]     rot_cnt;
   lop_e              lop;
   logic [SW-1:0]     rd_sel;
   wmode_e            wmode;
   logic              rmode;
   logic [PIX_W-1:0]  bit_mask;
   logic              rd_pend;
   logic [WW-1:0]     latch_q, latch_eff;
   logic [PIX_W-1:0]  rd_byte;

   plane_cfg_regs #(.PLANES(PLANES), .PIX_W(PIX_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .sr_val(sr_val), .sr_en(sr_en), .cmp_val(cmp_val), .care(care), .rot_cnt(rot_cnt),
      .lop(lop), .rd_sel(rd_sel), .wmode(wmode), .rmode(rmode), .bit_mask(bit_mask),
      .plane_en(plane_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         latch_q <= '0;
      end else begin
         rd_pend <= cpu_req && !cpu_we;
         if (rd_pend) latch_q <= mem_rdata;
      end
   end

   assign latch_eff = rd_pend ? mem_rdata : latch_q;

   plane_write_unit #(.PLANES(PLANES), .PIX_W(PIX_W)) i_wr (
      .cpu_wdata(cpu_wdata), .latch(latch_eff), .wmode(wmode), .lop(lop), .rot_cnt(rot_cnt),
      .sr_val(sr_val), .sr_en(sr_en), .bit_mask(bit_mask), .wdata(mem_wdata)
   );

   plane_read_unit #(.PLANES(PLANES), .PIX_W(PIX_W)) i_rd (
      .word(mem_rdata), .rmode(rmode), .rd_sel(rd_sel), .cmp_val(cmp_val), .care(care),
      .rdata(rd_byte)
   );

   assign mem_addr   = cpu_addr;
   assign mem_rd     = cpu_req && !cpu_we;
   assign mem_wr     = cpu_req && cpu_we;
   assign mem_wen    = mem_wr ? plane_en : '0;
   assign cpu_rvalid = rd_pend;
   assign cpu_rdata  = rd_pend ? rd_byte : '0;

   // R3
   read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we) |=> cpu_rvalid);

   // R3
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |=> (latch_q == $past(mem_rdata)));

   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rvalid |=> $stable(latch_q));

   // R7
   copy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && wmode == WM_LATCH) |-> (mem_wdata == latch_eff));

   // R6
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && (wmode == WM_DIRECT || wmode == WM_COLOR))
         |-> (((mem_wdata ^ latch_eff) & ~{PLANES{bit_mask}}) == '0));
endmodule

// File: tb/test_plane_rw_path.sv
module test_plane_rw_path;
   localparam int CLK_PERIOD = 10;
   localparam int PLANES = 4;
   localparam int PIX_W  = 8;
   localparam int ADDR_W = 4;
   localparam int WW = PLANES * PIX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [3:0]        cfg_idx = '0;
   logic [PIX_W-1:0]  cfg_wdata = '0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [PIX_W-1:0]  cpu_wdata = '0;
   logic [PIX_W-1:0]  cpu_rdata;
   logic              cpu_rvalid;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_rd, mem_wr;
   logic [PLANES-1:0] mem_wen;
   logic [WW-1:0]     mem_wdata;
   logic [WW-1:0]     mem_rdata;

   int n_chk = 0;
   int n_bad = 0;

   logic [WW-1:0] mem_m [16];
   logic [WW-1:0] exp_latch;

   always #(CLK_PERIOD/2) clk = ~clk;

   plane_rw_path #(.PLANES(PLANES), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) i_plane_rw_path (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wen(mem_wen), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // plane memory model: one-cycle read latency, per-plane write enables
   always @(posedge clk) begin
      if (mem_wr) begin
         for (int p = 0; p < PLANES; p++)
            if (mem_wen[p]) mem_m[mem_addr][p*PIX_W +: PIX_W] <= mem_wdata[p*PIX_W +: PIX_W];
      end
      if (mem_rd) mem_rdata <= mem_m[mem_addr];
   end

   task automatic chk(input logic ok, input string req, input logic [WW-1:0] act,
                      input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] model_write(
      input int wm, input int rot, input int op, input logic [3:0] srv, input logic [3:0] sre,
      input logic [7:0] bm, input logic [7:0] d, input logic [WW-1:0] lat);
      logic [15:0] dd;
      logic [7:0]  r, src, alu, m, lp;
      logic [WW-1:0] res;
      dd = {d, d} >> rot;
      r = dd[7:0];
      res = '0;
      for (int p = 0; p < PLANES; p++) begin
         lp = lat[p*8 +: 8];
         if (wm == 2) src = {8{d[p]}};
         else if (wm == 3) src = {8{srv[p]}};
         else src = sre[p] ? {8{srv[p]}} : r;
         case (op)
            1: alu = src & lp;
            2: alu = src | lp;
            3: alu = src ^ lp;
            default: alu = src;
         endcase
         m = (wm == 3) ? (r & bm) : bm;
         res[p*8 +: 8] = (wm == 1) ? lp : ((alu & m) | (lp & ~m));
      end
      return res;
   endfunction

   function automatic logic [7:0] model_cmp(input logic [WW-1:0] w, input logic [3:0] cv,
                                            input logic [3:0] cm);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         r[i] = 1'b1;
         for (int p = 0; p < PLANES; p++)
            if (cm[p] && (w[p*8 + i] != cv[p])) r[i] = 1'b0;
      end
      return r;
   endfunction

   task automatic cfg(input logic [3:0] idx, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cpu_rd(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic v);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      d = cpu_rdata; v = cpu_rvalid;
      exp_latch = mem_m[a];
   endtask

   task automatic cpu_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         output logic [PLANES-1:0] wen);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      #1 wen = mem_wen;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic t_reset();
      logic [PLANES-1:0] w;
      chk(!cpu_rvalid && !mem_rd && !mem_wr, "R1 idle after reset",
          {mem_rd, mem_wr, cpu_rvalid}, '0);
      cpu_wr(4'd3, 8'hA5, w);
      chk(mem_m[3] == 32'hA5A5A5A5, "R1 default write path", mem_m[3], 32'hA5A5A5A5);
      chk(w == 4'hF, "R1 R10 default plane enable", w, 4'hF);
   endtask

   task automatic t_read_sel();
      logic [7:0] d; logic v;
      cpu_rd(4'd0, d, v);
      chk(v, "R3 rvalid one cycle after read", v, 1);
      chk(d == 8'h11, "R11 plane 0 select", d, 8'h11);
      cfg(plane_pkg::IDX_RD_SEL, 8'd2);
      cpu_rd(4'd0, d, v);
      chk(d == 8'h33, "R2 R11 plane 2 select", d, 8'h33);
      cfg(plane_pkg::IDX_RD_SEL, 8'd3);
      cpu_rd(4'd1, d, v);
      chk(d == 8'hF0, "R11 plane 3 select", d, 8'hF0);
   endtask

   task automatic t_rot_op();
      logic [PLANES-1:0] w; logic [7:0] d; logic v; logic [WW-1:0] e;
      int rots[3] = '{0, 1, 7};
      for (int op = 0; op < 4; op++) begin
         for (int k = 0; k < 3; k++) begin
            cfg(plane_pkg::IDX_ROT_OP, 8'((op << 3) | rots[k]));
            cpu_rd(4'd1, d, v);
            cpu_wr(4'd4, 8'h3C, w);
            e = model_write(0, rots[k], op, 4'h0, 4'h0, 8'hFF, 8'h3C, exp_latch);
            chk(mem_m[4] == e, $sformatf("R4 op %0d rot %0d", op, rots[k]), mem_m[4], e);
         end
      end
      cfg(plane_pkg::IDX_ROT_OP, 8'h00);
   endtask

   task automatic t_set_reset();
      logic [PLANES-1:0] w; logic [7:0] d; logic v;
      cfg(plane_pkg::IDX_SR_EN, 8'h05);
      cfg(plane_pkg::IDX_SR_VAL, 8'h01);
      cpu_rd(4'd1, d, v);
      cpu_wr(4'd5, 8'h3C, w);
      chk(mem_m[5] == 32'h3C003CFF, "R5 set/reset per plane", mem_m[5], 32'h3C003CFF);
      cfg(plane_pkg::IDX_SR_EN, 8'h00);
   endtask

   task automatic t_bitmask();
      logic [PLANES-1:0] w; logic [7:0] d; logic v;
      cfg(plane_pkg::IDX_BITMASK, 8'h0F);
      cpu_rd(4'd1, d, v);
      cpu_wr(4'd6, 8'h00, w);
      chk(mem_m[6] == 32'hF000A050, "R6 mask keeps latch bits", mem_m[6], 32'hF000A050);
   endtask

   task automatic t_copy();
      logic [PLANES-1:0] w; logic [7:0] d; logic v;
      cfg(plane_pkg::IDX_MODE, 8'h01);
      cpu_rd(4'd0, d, v);
      cpu_wr(4'd7, 8'hFF, w);
      chk(mem_m[7] == 32'h44332211, "R7 latch copy ignores data and mask",
          mem_m[7], 32'h44332211);
   endtask

   task automatic t_colour();
      logic [PLANES-1:0] w; logic [7:0] d; logic v;
      cfg(plane_pkg::IDX_MODE, 8'h02);
      cfg(plane_pkg::IDX_BITMASK, 8'hF0);
      cpu_rd(4'd0, d, v);
      cpu_wr(4'd8, 8'hFA, w);
      chk(mem_m[8] == 32'hF403F201, "R8 colour write", mem_m[8], 32'hF403F201);
   endtask

   task automatic t_fill();
      logic [PLANES-1:0] w; logic [7:0] d; logic v; logic [WW-1:0] e;
      cfg(plane_pkg::IDX_MODE, 8'h03);
      cfg(plane_pkg::IDX_SR_VAL, 8'h06);
      cfg(plane_pkg::IDX_BITMASK, 8'h3C);
      cfg(plane_pkg::IDX_ROT_OP, 8'h01);
      cpu_rd(4'd1, d, v);
      cpu_wr(4'd9, 8'hE1, w);
      e = model_write(3, 1, 0, 4'h6, 4'h0, 8'h3C, 8'hE1, exp_latch);
      chk(mem_m[9] == e, "R9 fill with rotated mask", mem_m[9], e);
      cfg(plane_pkg::IDX_ROT_OP, 8'h00);
      cfg(plane_pkg::IDX_BITMASK, 8'hFF);
   endtask

   task automatic t_plane_en();
      logic [PLANES-1:0] w;
      cfg(plane_pkg::IDX_MODE, 8'h00);
      cfg(plane_pkg::IDX_PLANE_EN, 8'h0A);
      cpu_wr(4'd10, 8'h77, w);
      chk(w == 4'hA, "R10 write enable follows register", w, 4'hA);
      chk(mem_m[10] == 32'h77AD77EF, "R10 disabled planes untouched",
          mem_m[10], 32'h77AD77EF);
      cfg(plane_pkg::IDX_PLANE_EN, 8'h0F);
   endtask

   task automatic t_compare();
      logic [7:0] d, e; logic v;
      cfg(plane_pkg::IDX_MODE, 8'h08);
      cfg(plane_pkg::IDX_CMP, 8'h05);
      cfg(plane_pkg::IDX_CARE, 8'h0F);
      cpu_rd(4'd11, d, v);
      e = model_cmp(mem_m[11], 4'h5, 4'hF);
      chk(d == e, "R12 compare all planes", d, e);
      cfg(plane_pkg::IDX_CARE, 8'h03);
      cpu_rd(4'd11, d, v);
      e = model_cmp(mem_m[11], 4'h5, 4'h3);
      chk(d == e, "R12 compare partial care", d, e);
      cfg(plane_pkg::IDX_MODE, 8'h00);
   endtask

   task automatic t_forward();
      cfg(plane_pkg::IDX_ROT_OP, 8'h18);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'd1;
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = 4'd12; cpu_wdata = 8'hFF;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      chk(mem_m[12] == 32'h0FF055AA, "R13 write uses word just read",
          mem_m[12], 32'h0FF055AA);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem_m[i] = '0;
      mem_m[0]  = 32'h44332211;
      mem_m[1]  = 32'hF00FAA55;
      mem_m[10] = 32'hDEADBEEF;
      mem_m[11] = 32'h3CF00FFF;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_sel();
      t_rot_op();
      t_set_reset();
      t_bitmask();
      t_copy();
      t_colour();
      t_fill();
      t_plane_en();
      t_compare();
      t_forward();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule